// File: doc/BRIEF.md
# Supply-Voltage Monitor Reset Controller

This block is the digital half of a low-supply supervisor. Each cycle it receives the supply level as a synchronous digital code, compares it with a pair of trip levels, and keeps a hysteresis state. That state is set when the supply drops below a falling level. It is cleared only when the supply climbs above a strictly higher rising level. The block drives a status flag for software, an internal reset request and an active-low external reset pin.

Four static configuration bits shape its behaviour. A power-off bit silences the monitor completely. A reset-off bit leaves only the flag active, which gives a polled mode. A range bit chooses between the high-supply and the low-supply threshold pairs. A stop-run bit decides whether monitoring continues while the chip's stop input is asserted. When monitoring is suspended in stop, the last state is frozen.

Top module: `supply_guard`

## Requirements
- R1: When `cfg_pwr_off` is 1, the flag and the reset request are both 0 from the next clock edge on, whatever the level.
- R2: The reset request is set only when `cfg_rst_off` is 0 and the level is strictly below the selected falling threshold; while `cfg_rst_off` is 1 the request is 0 after the next edge.
- R3: Once set, the reset request stays 1 while the level is at or below the selected rising threshold, and clears on the edge after the level is strictly above it.
- R4: The flag is set when the level is strictly below the falling threshold, held when the level is equal to it or between the two thresholds, and cleared when the level is strictly above the rising threshold, independent of `cfg_rst_off`.
- R5: Polled mode (`cfg_pwr_off`=0, `cfg_rst_off`=1): the flag tracks the supply while the reset request stays 0 and the pin stays 1.
- R6: `cfg_hi_range`=1 uses thresholds HI_FALL/HI_RISE; `cfg_hi_range`=0 uses LO_FALL/LO_RISE.
- R7: While `stop_i` is 1 and `cfg_stop_run` is 0, the flag holds its value and no new reset is requested; with `cfg_stop_run`=1 monitoring continues normally during stop.
- R8: `rst_pin_n_o` is 0 exactly when the reset request is 1, and a reset request never occurs without the flag set.
- R9: A synchronous `rst` clears the flag and the request and sets the pin to 1.
- R10: All outputs are registered: they reflect the inputs present at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| level_i | input | LVL_W | Digitized supply level |
| cfg_pwr_off | input | 1 | 1 disables the monitor |
| cfg_rst_off | input | 1 | 1 disables reset requests (polled mode) |
| cfg_stop_run | input | 1 | 1 keeps monitoring during stop |
| cfg_hi_range | input | 1 | 1 selects high-supply thresholds |
| stop_i | input | 1 | Chip stop mode indicator |
| low_flag_o | output | 1 | Supply-low status flag |
| rst_req_o | output | 1 | Internal reset request |
| rst_pin_n_o | output | 1 | External reset pin, active low |

## Verification
Every output comes from a single register stage, so each result is due at the first rising edge after the stimulus that causes it. The bench applies inputs on the falling edge, advances its reference model on the following rising edge with those same inputs, and compares at the next falling edge. In that way each comparison covers exactly one cycle of latency. Hold behaviour, both at the threshold boundaries and during stop, is checked over several consecutive cycles, so that any premature change shows up.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    typedef struct packed {
        logic below;
        logic rreq;
    } sg_state_t;

endpackage

// File: rtl/sg_trip_sel.sv
module sg_trip_sel #(
    parameter int LVL_W   = 8,
    parameter int HI_FALL = 180,
    parameter int HI_RISE = 190,
    parameter int LO_FALL = 100,
    parameter int LO_RISE = 108
) (
    input  logic             hi_range,
    output logic [LVL_W-1:0] fall_lvl,
    output logic [LVL_W-1:0] rise_lvl
);
    localparam logic [LVL_W-1:0] HF = LVL_W'(HI_FALL);
    localparam logic [LVL_W-1:0] HR = LVL_W'(HI_RISE);
    localparam logic [LVL_W-1:0] LF = LVL_W'(LO_FALL);
    localparam logic [LVL_W-1:0] LR = LVL_W'(LO_RISE);

    always_comb begin
        fall_lvl = hi_range ? HF : LF;
        rise_lvl = hi_range ? HR : LR;
    end
endmodule

// File: rtl/sg_level_cmp.sv
module sg_level_cmp #(
    parameter int LVL_W = 8
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] fall_lvl,
    input  logic [LVL_W-1:0] rise_lvl,
    output logic             is_low,
    output logic             is_high
);
    always_comb begin
        is_low  = level < fall_lvl;
        is_high = level > rise_lvl;
    end
endmodule

// File: rtl/supply_guard.sv
module supply_guard
    import supply_guard_pkg::*;
#(
    parameter int LVL_W   = 8,
    parameter int HI_FALL = 180,
    parameter int HI_RISE = 190,
    parameter int LO_FALL = 100,
    parameter int LO_RISE = 108
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level_i,
    input  logic             cfg_pwr_off,
    input  logic             cfg_rst_off,
    input  logic             cfg_stop_run,
    input  logic             cfg_hi_range,
    input  logic             stop_i,
    output logic             low_flag_o,
    output logic             rst_req_o,
    output logic             rst_pin_n_o
);
    logic [LVL_W-1:0] fall_lvl;
    logic [LVL_W-1:0] rise_lvl;
    logic             is_low;
    logic             is_high;
    logic             run;
    sg_state_t        st_d, st_q;

    sg_trip_sel #(
        .LVL_W(LVL_W), .HI_FALL(HI_FALL), .HI_RISE(HI_RISE),
        .LO_FALL(LO_FALL), .LO_RISE(LO_RISE)
    ) u_trip (
        .hi_range(cfg_hi_range),
        .fall_lvl(fall_lvl),
        .rise_lvl(rise_lvl)
    );

    sg_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .level   (level_i),
        .fall_lvl(fall_lvl),
        .rise_lvl(rise_lvl),
        .is_low  (is_low),
        .is_high (is_high)
    );

    always_comb begin
        run  = !cfg_pwr_off && (!stop_i || cfg_stop_run);
        st_d = st_q;
        if (cfg_pwr_off) begin
            st_d = '0;
        end else if (run) begin
            if (is_low)       st_d.below = 1'b1;
            else if (is_high) st_d.below = 1'b0;
            if (cfg_rst_off)  st_d.rreq  = 1'b0;
            else if (is_low)  st_d.rreq  = 1'b1;
            else if (is_high) st_d.rreq  = 1'b0;
        end else if (cfg_rst_off) begin
            st_d.rreq = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign low_flag_o  = st_q.below;
    assign rst_req_o   = st_q.rreq;
    assign rst_pin_n_o = ~st_q.rreq;
endmodule

// File: rtl/supply_guard_checker.sv
module supply_guard_checker #(
    parameter int LVL_W   = 8,
    parameter int HI_FALL = 180,
    parameter int HI_RISE = 190,
    parameter int LO_FALL = 100,
    parameter int LO_RISE = 108
) (
    input logic             clk,
    input logic             rst,
    input logic [LVL_W-1:0] level_i,
    input logic             cfg_pwr_off,
    input logic             cfg_rst_off,
    input logic             cfg_stop_run,
    input logic             cfg_hi_range,
    input logic             stop_i,
    input logic             low_flag_o,
    input logic             rst_req_o,
    input logic             rst_pin_n_o
);
    logic awake;
    int   fall_i, rise_i;
    always_comb begin
        awake  = !cfg_pwr_off && (!stop_i || cfg_stop_run);
        fall_i = cfg_hi_range ? HI_FALL : LO_FALL;
        rise_i = cfg_hi_range ? HI_RISE : LO_RISE;
    end

    AST_PWR_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        cfg_pwr_off |=> (!low_flag_o && !rst_req_o)); // R1
    AST_RST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        cfg_rst_off |=> !rst_req_o); // R2
    AST_RELEASE_ABOVE_RISE: assert property (@(posedge clk) disable iff (rst)
        (awake && int'(level_i) > rise_i) |=> (!rst_req_o && !low_flag_o)); // R3
    AST_SET_BELOW_FALL: assert property (@(posedge clk) disable iff (rst)
        (awake && int'(level_i) < fall_i) |=> low_flag_o); // R4
    AST_STOP_HOLDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !cfg_stop_run && !cfg_pwr_off) |=> $stable(low_flag_o)); // R7
    AST_STOP_NO_NEW_REQ: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !cfg_stop_run && !rst_req_o) |=> !rst_req_o); // R7
    AST_PIN_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n_o |-> low_flag_o); // R8
endmodule

bind supply_guard supply_guard_checker #(
    .LVL_W(LVL_W), .HI_FALL(HI_FALL), .HI_RISE(HI_RISE),
    .LO_FALL(LO_FALL), .LO_RISE(LO_RISE)
) u_sg_chk (.*);

// File: tb/supply_guard_bench.sv
module supply_guard_bench;
    localparam int LVL_W = 8;
    localparam int HF = 180, HR = 190, LF = 100, LR = 108;

    logic clk = 1'b0;
    logic rst;
    logic [LVL_W-1:0] level_i;
    logic cfg_pwr_off, cfg_rst_off, cfg_stop_run, cfg_hi_range, stop_i;
    logic low_flag_o, rst_req_o, rst_pin_n_o;

    int checks = 0;
    int errors = 0;
    logic m_below = 1'b0;
    logic m_rreq  = 1'b0;

    always #5 clk = ~clk;

    supply_guard #(.LVL_W(LVL_W), .HI_FALL(HF), .HI_RISE(HR),
                   .LO_FALL(LF), .LO_RISE(LR)) u_supply_guard (.*);

    function automatic logic [1:0] model_next(logic b, logic r, int lvl,
        logic poff, logic roff, logic srun, logic hi, logic stp, logic rs);
        int f, u;
        logic nb, nr;
        f = hi ? HF : LF;
        u = hi ? HR : LR;
        nb = b; nr = r;
        if (rs || poff) begin
            nb = 0; nr = 0;
        end else if (!stp || srun) begin
            if (lvl < f)      nb = 1;
            else if (lvl > u) nb = 0;
            if (roff)         nr = 0;
            else if (lvl < f) nr = 1;
            else if (lvl > u) nr = 0;
        end else if (roff) begin
            nr = 0;
        end
        return {nb, nr};
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // apply inputs at negedge, step model at posedge, compare at next negedge
    task automatic step(int lvl, logic poff, logic roff, logic srun,
                        logic hi, logic stp, string tag);
        logic [1:0] n;
        level_i = LVL_W'(lvl); cfg_pwr_off = poff; cfg_rst_off = roff;
        cfg_stop_run = srun; cfg_hi_range = hi; stop_i = stp;
        @(posedge clk);
        n = model_next(m_below, m_rreq, lvl, poff, roff, srun, hi, stp, rst);
        m_below = n[1]; m_rreq = n[0];
        @(negedge clk);
        check({tag, " flag"}, low_flag_o, m_below);
        check({tag, " req"},  rst_req_o,  m_rreq);
        check({tag, " pin"},  rst_pin_n_o, ~m_rreq);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        level_i = '0; cfg_pwr_off = 0; cfg_rst_off = 0; cfg_stop_run = 0;
        cfg_hi_range = 0; stop_i = 0;
        @(negedge clk);
        step(50, 0, 0, 0, 0, 0, "R9 reset");
        rst = 1'b0;

        // R4/R3 boundaries, low range (R6)
        step(LF, 0, 0, 0, 0, 0, "R4 equal fall no set");
        step(LF - 1, 0, 0, 0, 0, 0, "R2 R4 set below fall");
        step(LR, 0, 0, 0, 0, 0, "R3 equal rise holds");
        step(LF + 3, 0, 0, 0, 0, 0, "R3 between holds");
        step(LR + 1, 0, 0, 0, 0, 0, "R3 release above rise");
        // R6 high range: level 150 is low in high range but not low range
        step(150, 0, 0, 0, 0, 0, "R6 low range no trip");
        step(150, 0, 0, 0, 1, 0, "R6 high range trips");
        step(HR + 1, 0, 0, 0, 1, 0, "R6 high range release");
        // R5 polled mode
        step(20, 0, 1, 0, 0, 0, "R5 polled flag set");
        step(20, 0, 1, 0, 0, 0, "R5 polled no req");
        step(200, 0, 1, 0, 0, 0, "R5 polled flag clears");
        // R7 stop hold
        step(200, 0, 0, 0, 0, 1, "R7 stop idle");
        step(10, 0, 0, 0, 0, 1, "R7 stop no new reset");
        step(10, 0, 0, 0, 0, 1, "R7 stop still held");
        step(10, 0, 0, 1, 0, 1, "R7 stop run trips");
        step(10, 0, 0, 0, 0, 1, "R7 stop holds asserted");
        step(250, 0, 0, 0, 0, 1, "R7 stop holds despite high");
        step(250, 0, 0, 0, 0, 0, "R10 leave stop release");
        // R1 power off
        step(5, 0, 0, 0, 0, 0, "R8 pin low");
        step(5, 1, 0, 0, 0, 0, "R1 power off clears");
        step(5, 1, 0, 1, 1, 0, "R1 power off stays quiet");
        // R2 reset-off clears active request
        step(5, 0, 0, 0, 0, 0, "R2 req set");
        step(5, 0, 1, 0, 0, 0, "R2 reset off clears req");
        // R9 mid-run reset
        step(5, 0, 0, 0, 0, 0, "R2 req set again");
        rst = 1'b1;
        step(5, 0, 0, 0, 0, 0, "R9 sync reset clears");
        rst = 1'b0;

        for (int i = 0; i < 3000; i++) begin
            int lvl, sel;
            logic hi;
            hi  = 1'($urandom);
            sel = int'($urandom % 4);
            if (sel == 0) lvl = int'($urandom % 256);
            else if (sel == 1) lvl = (hi ? HF : LF) + int'($urandom % 5) - 2;
            else if (sel == 2) lvl = (hi ? HR : LR) + int'($urandom % 5) - 2;
            else lvl = (hi ? HF : LF) + int'($urandom % 12);
            step(lvl, ($urandom % 16) == 0, ($urandom % 4) == 0,
                 1'($urandom), hi, ($urandom % 4) == 0, "R10 random R4 R2 R8");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule